// File: doc/BRIEF.md
# Multi-Scale Optical Flow Merge Unit

This block sits at the end of each scale of a coarse-to-fine optical flow pipeline. It receives two pixel streams. One carries the flow estimate from the previous, coarser scale after upscaling. The other carries the correction estimated at the current scale. Each stream item holds a horizontal and a vertical velocity component and a non-valid bit. For the current-scale stream, the non-valid bit comes from a confidence threshold applied upstream. The unit adds the two estimates pixel by pixel with saturation and produces the merged flow. That result is stored outside the block for the next iteration.

The unit also carries the per-pixel non-valid marker from the coarse scales toward the fine ones. On intermediate scales either source can mark a pixel unusable. On the finest scale both sources must agree before the pixel is discarded. The finest-scale indication travels with each current-stream item.

The two streams arrive with independent valid strobes and no back-pressure. A small queue on each side lets either stream run up to `SKEW` items ahead of the other. A four-state controller tracks which side holds entries:

- **IDLE**: both queues are empty.
- **PREV_LEAD**: only the previous queue holds entries.
- **CURR_LEAD**: only the current queue holds entries.
- **PAIRED**: both queues hold entries.

The controller moves from IDLE to PREV_LEAD or CURR_LEAD when one side arrives alone. It moves to PAIRED whenever both sides hold data. It falls back to a lead state or to IDLE when a side drains. One pair is merged in every PAIRED cycle.

Top module: `flow_merge_unit`

## Requirements
- R1: When the merged pixel is valid, `out_vx` equals the signed 12-bit two's-complement sum of the paired previous and current horizontal components, provided that sum lies within [-2048, 2047].
- R2: When the merged pixel is valid, `out_vy` equals the signed sum of the paired vertical components, under the same range condition as R1.
- R3: A component sum above 2047 gives 2047, and a sum below -2048 gives -2048. The sum never wraps.
- R4: For a current item whose finest flag (`cur_finest`) is 0, `out_nv` is the OR of the two non-valid bits.
- R5: For a current item whose finest flag is 1, `out_nv` is the AND of the two non-valid bits.
- R6: Whenever `out_nv` is 1 with `out_valid`, both `out_vx` and `out_vy` are zero.
- R7: The k-th previous item is always merged with the k-th current item, and exactly one output is produced per pair. No output appears while only one stream has delivered. Either stream may lead the other by up to `SKEW` (default 4) items without loss.
- R8: For an aligned pair presented in a cycle while both queues are empty, `out_valid` is high during the second cycle after that cycle and low during the first.
- R9: While `rst_n` is low, `out_valid` is 0 and `out_vx`, `out_vy` and `out_nv` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| prev_valid | input | 1 | Previous-scale item present this cycle |
| prev_vx | input | FLOW_W | Previous horizontal flow, signed |
| prev_vy | input | FLOW_W | Previous vertical flow, signed |
| prev_nv | input | 1 | Previous non-valid marker |
| cur_valid | input | 1 | Current-scale item present this cycle |
| cur_vx | input | FLOW_W | Current horizontal flow, signed |
| cur_vy | input | FLOW_W | Current vertical flow, signed |
| cur_nv | input | 1 | Current non-valid marker |
| cur_finest | input | 1 | Item belongs to the finest scale |
| out_valid | output | 1 | Merged pixel present this cycle |
| out_vx | output | FLOW_W | Merged horizontal flow, signed |
| out_vy | output | FLOW_W | Merged vertical flow, signed |
| out_nv | output | 1 | Merged non-valid marker |

## Verification
The queue assertion takes for granted that the upstream producers never let one stream get more than `SKEW` items ahead of the other. The unit has no way to stall a producer, so a larger lead would overrun a queue. The random stimulus counts the items it has sent on each side and withholds a strobe whenever sending it would break that bound. The directed part pushes one side exactly `SKEW` items ahead and then holds it there for several idle cycles. The merge-rule assertions assume the finest flag belongs to the current item, and the bench drives it as part of that item.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PREV_LEAD = 2'd1,
        ST_CURR_LEAD = 2'd2,
        ST_PAIRED    = 2'd3
    } merge_state_e;
endpackage

// File: rtl/fm_skew_fifo.sv
module fm_skew_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_q,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_next
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout     = store[rd_ptr];
    assign cnt_next = cnt_q + CNT_W'(push) - CNT_W'(pop);

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            cnt_q <= cnt_next;
        end
    end
endmodule

// File: rtl/fm_sat_add.sv
module fm_sat_add #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        wide = {a[W-1], a} + {b[W-1], b};
        if (wide[W] != wide[W-1]) y = wide[W] ? MIN_V : MAX_V;
        else                      y = wide[W-1:0];
    end
endmodule

// File: rtl/flow_merge_unit.sv
module flow_merge_unit
    import fm_pkg::*;
#(
    parameter int FLOW_W = 12,
    parameter int SKEW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prev_valid,
    input  logic [FLOW_W-1:0] prev_vx,
    input  logic [FLOW_W-1:0] prev_vy,
    input  logic              prev_nv,
    input  logic              cur_valid,
    input  logic [FLOW_W-1:0] cur_vx,
    input  logic [FLOW_W-1:0] cur_vy,
    input  logic              cur_nv,
    input  logic              cur_finest,
    output logic              out_valid,
    output logic [FLOW_W-1:0] out_vx,
    output logic [FLOW_W-1:0] out_vy,
    output logic              out_nv
);
    localparam int DEPTH = SKEW + 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PW    = 2 * FLOW_W + 1;
    localparam int CW    = 2 * FLOW_W + 2;
    localparam int NCOMP = 2;

    merge_state_e state_q, state_d;

    logic [PW-1:0]    prev_head;
    logic [CW-1:0]    cur_head;
    logic [CNT_W-1:0] prev_cnt, prev_cnt_n, cur_cnt, cur_cnt_n;
    logic             pop;

    logic signed [FLOW_W-1:0] a_c [NCOMP];
    logic signed [FLOW_W-1:0] b_c [NCOMP];
    logic signed [FLOW_W-1:0] s_c [NCOMP];

    logic prev_head_nv, cur_head_nv, cur_head_fine, nv_merge;

    assign pop = (state_q == ST_PAIRED);

    fm_skew_fifo #(.W(PW), .DEPTH(DEPTH)) prev_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(prev_valid), .din({prev_nv, prev_vy, prev_vx}),
        .pop(pop), .dout(prev_head),
        .cnt_q(prev_cnt), .cnt_next(prev_cnt_n)
    );

    fm_skew_fifo #(.W(CW), .DEPTH(DEPTH)) cur_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(cur_valid), .din({cur_finest, cur_nv, cur_vy, cur_vx}),
        .pop(pop), .dout(cur_head),
        .cnt_q(cur_cnt), .cnt_next(cur_cnt_n)
    );

    assign prev_head_nv  = prev_head[2*FLOW_W];
    assign cur_head_nv   = cur_head[2*FLOW_W];
    assign cur_head_fine = cur_head[2*FLOW_W+1];

    // Finest scale needs both sources to reject; coarser scales reject on either.
    assign nv_merge = cur_head_fine ? (prev_head_nv & cur_head_nv)
                                    : (prev_head_nv | cur_head_nv);

    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
        assign a_c[c] = prev_head[c*FLOW_W +: FLOW_W];
        assign b_c[c] = cur_head[c*FLOW_W +: FLOW_W];
        fm_sat_add #(.W(FLOW_W)) add_i (.a(a_c[c]), .b(b_c[c]), .y(s_c[c]));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state from the occupancy both queues will have after this edge
    always_comb begin
        unique case ({prev_cnt_n != '0, cur_cnt_n != '0})
            2'b00: state_d = ST_IDLE;
            2'b10: state_d = ST_PREV_LEAD;
            2'b01: state_d = ST_CURR_LEAD;
            2'b11: state_d = ST_PAIRED;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vx    <= '0;
            out_vy    <= '0;
            out_nv    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PAIRED: begin
                    out_valid <= 1'b1;
                    out_nv    <= nv_merge;
                    out_vx    <= nv_merge ? '0 : s_c[0];
                    out_vy    <= nv_merge ? '0 : s_c[1];
                end
                ST_IDLE, ST_PREV_LEAD, ST_CURR_LEAD: begin
                    out_valid <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fm_checker.sv
module fm_checker
    import fm_pkg::*;
#(
    parameter int FLOW_W = 12,
    parameter int DEPTH  = 5,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [FLOW_W-1:0] out_vx,
    input logic [FLOW_W-1:0] out_vy,
    input logic              out_nv,
    input logic              prev_valid,
    input logic              cur_valid,
    input logic [CNT_W-1:0]  prev_cnt,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic              pop,
    input merge_state_e      state_q,
    input logic              prev_head_nv,
    input logic              cur_head_nv,
    input logic              cur_head_fine
);
    assert_prev_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_cnt == CNT_W'(DEPTH)) |-> (!prev_valid || pop));

    assert_cur_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cnt == CNT_W'(DEPTH)) |-> (!cur_valid || pop));

    assert_out_follows_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state_q == ST_PAIRED));

    assert_zero_when_nonvalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nv) |-> (out_vx == '0 && out_vy == '0));

    assert_coarse_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(cur_head_fine)) |->
            (out_nv == ($past(prev_head_nv) || $past(cur_head_nv))));

    assert_finest_and_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_head_fine)) |->
            (out_nv == ($past(prev_head_nv) && $past(cur_head_nv))));
endmodule

bind flow_merge_unit fm_checker #(
    .FLOW_W(FLOW_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_vx(out_vx), .out_vy(out_vy), .out_nv(out_nv),
    .prev_valid(prev_valid), .cur_valid(cur_valid),
    .prev_cnt(prev_cnt), .cur_cnt(cur_cnt), .pop(pop), .state_q(state_q),
    .prev_head_nv(prev_head_nv), .cur_head_nv(cur_head_nv),
    .cur_head_fine(cur_head_fine)
);

// File: tb/flow_merge_unit_tb.sv
module flow_merge_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FLOW_W     = 12;
    localparam int SKEW       = 4;
    localparam int MAXN       = 4096;
    localparam int WD_CYCLES  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prev_valid = 1'b0, cur_valid = 1'b0;
    logic [FLOW_W-1:0] prev_vx = '0, prev_vy = '0, cur_vx = '0, cur_vy = '0;
    logic prev_nv = 1'b0, cur_nv = 1'b0, cur_finest = 1'b0;
    logic out_valid, out_nv;
    logic signed [FLOW_W-1:0] out_vx, out_vy;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_merge_unit #(.FLOW_W(FLOW_W), .SKEW(SKEW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .prev_valid(prev_valid), .prev_vx(prev_vx), .prev_vy(prev_vy), .prev_nv(prev_nv),
        .cur_valid(cur_valid), .cur_vx(cur_vx), .cur_vy(cur_vy), .cur_nv(cur_nv),
        .cur_finest(cur_finest),
        .out_valid(out_valid), .out_vx(out_vx), .out_vy(out_vy), .out_nv(out_nv)
    );

    int n_checks = 0, n_fail = 0;
    int p_vx [MAXN], p_vy [MAXN], c_vx [MAXN], c_vy [MAXN];
    bit p_nv [MAXN], c_nv [MAXN], c_fn [MAXN];
    int n_prev = 0, n_cur = 0, n_out = 0;
    int cyc = 0;
    bit done = 0;

    function automatic int sat(input int s);
        if (s > 2047)  return 2047;
        if (s < -2048) return -2048;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitor: compares each merged pixel with the bench's own model
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            int k, sx, sy, evx, evy;
            bit env;
            k = n_out;
            env = c_fn[k] ? (p_nv[k] & c_nv[k]) : (p_nv[k] | c_nv[k]);
            sx  = p_vx[k] + c_vx[k];
            sy  = p_vy[k] + c_vy[k];
            evx = env ? 0 : sat(sx);
            evy = env ? 0 : sat(sy);
            check(out_nv == env, c_fn[k] ? "R5" : "R4", int'(out_nv), int'(env));
            check(int'(out_vx) == evx,
                  env ? "R6" : ((sx != sat(sx)) ? "R3" : "R1"), int'(out_vx), evx);
            check(int'(out_vy) == evy,
                  env ? "R6" : ((sy != sat(sy)) ? "R3" : "R2"), int'(out_vy), evy);
            n_out++;
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_CYCLES && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_CYCLES);
            summary();
        end
    end

    task automatic drive(input bit dp, input int pvx, input int pvy, input bit pn,
                         input bit dc, input int cvx, input int cvy, input bit cn,
                         input bit cf);
        @(negedge clk);
        prev_valid = dp;
        cur_valid  = dc;
        if (dp) begin
            prev_vx = FLOW_W'(pvx); prev_vy = FLOW_W'(pvy); prev_nv = pn;
            p_vx[n_prev] = pvx; p_vy[n_prev] = pvy; p_nv[n_prev] = pn;
            n_prev++;
        end
        if (dc) begin
            cur_vx = FLOW_W'(cvx); cur_vy = FLOW_W'(cvy); cur_nv = cn; cur_finest = cf;
            c_vx[n_cur] = cvx; c_vy[n_cur] = cvy; c_nv[n_cur] = cn; c_fn[n_cur] = cf;
            n_cur++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic pair(input int pvx, input int pvy, input bit pn,
                        input int cvx, input int cvy, input bit cn, input bit cf);
        drive(1, pvx, pvy, pn, 1, cvx, cvy, cn, cf);
    endtask

    function automatic int rnd_comp();
        int r;
        r = int'($urandom_range(0, 9));
        if (r == 0) return 2047 - int'($urandom_range(0, 3));
        if (r == 1) return -2048 + int'($urandom_range(0, 3));
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    initial begin
        int seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9", int'(out_valid), 0);
        check(out_vx == '0 && out_vy == '0 && out_nv == 1'b0, "R9", int'(out_vx), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R8: latency of one aligned pair into empty queues
        pair(10, -20, 0, 5, 7, 0, 0);
        idle(1);
        check(out_valid == 1'b0, "R8", int'(out_valid), 0);
        idle(1);
        check(out_valid == 1'b1, "R8", int'(out_valid), 1);
        idle(3);

        // R7: previous stream leads by SKEW, held there while idle
        seen = n_out;
        for (int i = 0; i < SKEW; i++) drive(1, 100 + i, -i, 0, 0, 0, 0, 0, 0);
        idle(4);
        check(n_out == seen, "R7", n_out, seen);
        for (int i = 0; i < SKEW; i++) drive(0, 0, 0, 0, 1, i, 3 * i, 0, 0);
        idle(4);
        check(n_out == seen + SKEW, "R7", n_out, seen + SKEW);

        // R7: current stream leads by SKEW
        seen = n_out;
        for (int i = 0; i < SKEW; i++) drive(0, 0, 0, 0, 1, -50 * i, 9, 0, 1);
        idle(3);
        check(n_out == seen, "R7", n_out, seen);
        for (int i = 0; i < SKEW; i++) drive(1, 7 * i, -3, 0, 1, 1, 1, 0, 0);
        idle(6);

        // R3: saturation corners
        pair(2047, -2048, 0, 1, -1, 0, 0);
        pair(-2048, 2047, 0, -5, 2047, 0, 1);
        pair(2047, -2048, 0, -2048, 2047, 0, 0);
        pair(1000, -1000, 0, -3000 + 4096, 1024, 0, 0);
        // R4/R5/R6: all non-valid combinations on both scale kinds
        for (int f = 0; f < 2; f++)
            for (int m = 0; m < 4; m++)
                pair(300, -400, m[1], 11, 22, m[0], f[0]);
        idle(4);

        // Random traffic with the lead kept within SKEW items
        for (int i = 0; i < 2000; i++) begin
            bit dp, dc;
            dp = ($urandom_range(0, 3) != 0);
            dc = ($urandom_range(0, 3) != 0);
            if (dp && !dc && (n_prev - n_cur) >= SKEW) dp = 0;
            if (dc && !dp && (n_cur - n_prev) >= SKEW) dc = 0;
            drive(dp, rnd_comp(), rnd_comp(), ($urandom_range(0, 3) == 0),
                  dc, rnd_comp(), rnd_comp(), ($urandom_range(0, 3) == 0),
                  $urandom_range(0, 1) == 1);
            if (n_prev >= MAXN - 8 || n_cur >= MAXN - 8) break;
        end
        // Balance the streams, then drain
        while (n_prev < n_cur) drive(1, 1, 1, 0, 0, 0, 0, 0, 0);
        while (n_cur < n_prev) drive(0, 0, 0, 0, 1, 2, 2, 0, 0);
        idle(10);
        check(n_out == n_prev, "R7", n_out, n_prev);
        done = 1;
        summary();
    end
endmodule